// File: doc/BRIEF.md
# Serial Register Port with Order-Dependent Burst Addressing

This block is the serial slave front end of a configuration register space. A host selects it by pulling the active-low select line low, sends a 16-bit instruction, and then moves one or more data bytes. Each byte is turned into a one-cycle write or read strobe on a byte-wide parallel register bus. The serial clock, select line and data input are brought into the system clock domain through a synchronizer, and all decoding runs on the system clock.

One setting chooses the bit order. That single setting fixes the order in which bits are shifted and also the direction in which the register address moves during a burst: it counts down when the most significant bit comes first and up when the least significant bit comes first. A second setting chooses the pin mode. In 3-wire mode one bidirectional data pin carries both directions. In 4-wire mode read data leaves on a dedicated output. The block exports output enables instead of driving pads.

Both settings live in a small mode byte that the port holds at register address 0. The byte is mirrored across its two nibbles, so it decodes the same way under either bit order. A new setting is picked up when the next frame starts.

Top module: `spi_slave_port`

## Requirements
- R1: While reset is asserted and while the port is deselected, both output enables are low and no bus strobe is issued.
- R2: The instruction is 16 bits wide. Bit 15 is the direction (1 = read). Bits 14:13 are the byte count (00 = 1, 01 = 2, 10 = 3, 11 = stream until deselect). Bits 12:0 are the start address. Bytes sent after the counted number are ignored.
- R3: With MSB-first order (the reset setting), the instruction and data shift bit 15/bit 7 first, and the address decrements by one after each byte, wrapping from 0x0000 to 0x1FFF.
- R4: With LSB-first order, the instruction and data shift bit 0 first, and the address increments by one after each byte, wrapping from 0x1FFF to 0x0000.
- R5: A write issues `reg_wr` for one clock, with address and data, a few clocks after the eighth data bit. A read issues `reg_rd` for one clock, and `reg_rdata` is taken in that same cycle. Address 0 never appears with a strobe.
- R6: Address 0 is the mode byte. It reads as {4-wire, lsb, 0, 1, 1, 0, lsb, 4-wire} with bit 7 on the left, which is 0x18 after reset, so the instruction-length bit 3 always reads 1. A write takes bit 1 as LSB-first and bit 0 as 4-wire.
- R7: A mode-byte write does not change the bit order or pin mode of the frame that carries it. The new setting applies from the next frame.
- R8: In 3-wire mode `spi_sdio_oe` is high during the read data phase, and `spi_sdo_oe` stays low.
- R9: In 4-wire mode `spi_sdo_oe` is high during the read data phase, and `spi_sdio_oe` stays low.
- R10: Input bits are taken on serial clock rising edges. Read bits are launched on falling edges, starting with the falling edge that follows the 16th instruction bit.
- R11: Deasserting select at any point aborts the frame. An unfinished byte is not written, output enables drop, and the next frame decodes cleanly.
- R12: After the last counted byte of a read, the output enable drops before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low select |
| spi_sdio_i | input | 1 | Bidirectional data pin, input side |
| spi_sdio_o | output | 1 | Bidirectional data pin, output side |
| spi_sdio_oe | output | 1 | Output enable for the bidirectional pin |
| spi_sdo_o | output | 1 | Dedicated serial output |
| spi_sdo_oe | output | 1 | Output enable for the dedicated output |
| reg_addr | output | 13 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register bus read data, valid while `reg_rd` is high |

## Verification
A bit counter that is out of step shows up on the bus within one byte. The write lands on the wrong address or carries a rotated value, and in a read the byte on the pin comes out rotated. A stale or wrong order setting reverses every byte and moves burst addresses the wrong way at the second byte, so the bench uses asymmetric data patterns and bursts that cross the wrap point in both directions. A wrong pin-mode or state register appears on the first sampled read bit, as the wrong enable or a missing enable. A frame that does not abort is caught by a spurious or missing strobe in the scoreboard before the next frame ends.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_INSTR,
    FR_WDATA,
    FR_RDATA,
    FR_DONE
  } frame_state_e;

  typedef struct packed {
    logic lsb_first;
    logic four_wire;
  } port_mode_t;

  localparam port_mode_t MODE_RESET = '{lsb_first: 1'b0, four_wire: 1'b0};
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic din_in,
  output logic csn_s,
  output logic din_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  // chain entry layout: {csn, sclk, din}
  logic [STAGES-1:0][2:0] chain_q, chain_d;
  logic sclk_prev_q, sclk_prev_d;
  logic sclk_s;

  always_comb begin
    chain_d[0] = {csn_in, sclk_in, din_in};
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    sclk_prev_d = sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q     <= {STAGES{3'b100}};
      sclk_prev_q <= 1'b0;
    end else begin
      chain_q     <= chain_d;
      sclk_prev_q <= sclk_prev_d;
    end
  end

  assign csn_s     = chain_q[STAGES-1][2];
  assign sclk_s    = chain_q[STAGES-1][1];
  assign din_s     = chain_q[STAGES-1][0];
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
endmodule

// File: rtl/spi_mode_reg.sv
module spi_mode_reg
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_bits,
  output port_mode_t        mode,
  output logic [BYTE_W-1:0] rd_byte
);
  port_mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d.lsb_first = wr_bits[1];
      mode_d.four_wire = wr_bits[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
  // mirrored nibbles; bit 3 (long instruction) is fixed to 1
  assign rd_byte = {mode_q.four_wire, mode_q.lsb_first, 1'b0, 1'b1,
                    1'b1, 1'b0, mode_q.lsb_first, mode_q.four_wire};
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_port_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csn_s,
  input  logic              din_s,
  input  port_mode_t        mode_cfg,
  input  logic [BYTE_W-1:0] mode_byte,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              mode_we,
  output logic              out_bit,
  output logic              rd_active,
  output logic              act_four_wire
);
  localparam int INSTR_W = ADDR_W + 3;
  localparam int CNT_W   = $clog2(INSTR_W);
  localparam int DPOS_W  = $clog2(BYTE_W);

  frame_state_e        state_q, state_d;
  logic [CNT_W-1:0]    bitcnt_q, bitcnt_d;
  logic [INSTR_W-1:0]  ishift_q, ishift_d, ishift_nx;
  logic [BYTE_W-1:0]   dshift_q, dshift_d, dshift_nx;
  logic [ADDR_W-1:0]   addr_q, addr_d, addr_step;
  logic [1:0]          rem_q, rem_d;
  logic                stream_q, stream_d;
  port_mode_t          act_q, act_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic                out_q, out_d;
  logic [ADDR_W-1:0]   baddr_q, baddr_d;
  logic [BYTE_W-1:0]   bwdata_q, bwdata_d;
  logic                wrp_q, wrp_d, rdp_q, rdp_d;
  logic                more, last_instr, last_data, addr_zero;
  logic [DPOS_W-1:0]   dpos, tx_pos;

  assign ishift_nx  = act_q.lsb_first ? {din_s, ishift_q[INSTR_W-1:1]}
                                      : {ishift_q[INSTR_W-2:0], din_s};
  assign dshift_nx  = act_q.lsb_first ? {din_s, dshift_q[BYTE_W-1:1]}
                                      : {dshift_q[BYTE_W-2:0], din_s};
  assign addr_step  = act_q.lsb_first ? addr_q + 1'b1 : addr_q - 1'b1;
  assign more       = stream_q || (rem_q != 2'd0);
  assign last_instr = (bitcnt_q == CNT_W'(INSTR_W - 1));
  assign last_data  = (bitcnt_q == CNT_W'(BYTE_W - 1));
  assign dpos       = bitcnt_q[DPOS_W-1:0];
  assign tx_pos     = act_q.lsb_first ? dpos : DPOS_W'(BYTE_W - 1) - dpos;
  assign addr_zero  = (baddr_q == '0);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    ishift_d = ishift_q;
    dshift_d = dshift_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    stream_d = stream_q;
    act_d    = act_q;
    out_d    = out_q;
    baddr_d  = baddr_q;
    bwdata_d = bwdata_q;
    wrp_d    = 1'b0;
    rdp_d    = 1'b0;
    tx_d     = tx_q;
    if (rdp_q) tx_d = addr_zero ? mode_byte : bus_rdata;

    if (state_q == FR_IDLE) begin
      bitcnt_d = '0;
      if (!csn_s) begin
        state_d = FR_INSTR;
        act_d   = mode_cfg;
      end
    end else if (csn_s) begin
      state_d  = FR_IDLE;
      bitcnt_d = '0;
    end else begin
      case (state_q)
        FR_INSTR: if (sclk_rise) begin
          ishift_d = ishift_nx;
          bitcnt_d = bitcnt_q + 1'b1;
          if (last_instr) begin
            bitcnt_d = '0;
            addr_d   = ishift_nx[ADDR_W-1:0];
            rem_d    = ishift_nx[ADDR_W+1:ADDR_W];
            stream_d = &ishift_nx[ADDR_W+1:ADDR_W];
            if (ishift_nx[INSTR_W-1]) begin
              state_d = FR_RDATA;
              rdp_d   = 1'b1;
              baddr_d = ishift_nx[ADDR_W-1:0];
            end else begin
              state_d = FR_WDATA;
            end
          end
        end
        FR_WDATA: if (sclk_rise) begin
          dshift_d = dshift_nx;
          bitcnt_d = bitcnt_q + 1'b1;
          if (last_data) begin
            bitcnt_d = '0;
            wrp_d    = 1'b1;
            baddr_d  = addr_q;
            bwdata_d = dshift_nx;
            addr_d   = addr_step;
            if (!more)          state_d = FR_DONE;
            else if (!stream_q) rem_d   = rem_q - 1'b1;
          end
        end
        FR_RDATA: begin
          if (sclk_fall) out_d = tx_q[tx_pos];
          if (sclk_rise) begin
            bitcnt_d = bitcnt_q + 1'b1;
            if (last_data) begin
              bitcnt_d = '0;
              addr_d   = addr_step;
              if (!more) begin
                state_d = FR_DONE;
              end else begin
                if (!stream_q) rem_d = rem_q - 1'b1;
                rdp_d   = 1'b1;
                baddr_d = addr_step;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FR_IDLE;
      bitcnt_q <= '0;
      ishift_q <= '0;
      dshift_q <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      stream_q <= 1'b0;
      act_q    <= MODE_RESET;
      tx_q     <= '0;
      out_q    <= 1'b0;
      baddr_q  <= '0;
      bwdata_q <= '0;
      wrp_q    <= 1'b0;
      rdp_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      ishift_q <= ishift_d;
      dshift_q <= dshift_d;
      addr_q   <= addr_d;
      rem_q    <= rem_d;
      stream_q <= stream_d;
      act_q    <= act_d;
      tx_q     <= tx_d;
      out_q    <= out_d;
      baddr_q  <= baddr_d;
      bwdata_q <= bwdata_d;
      wrp_q    <= wrp_d;
      rdp_q    <= rdp_d;
    end
  end

  assign bus_addr      = baddr_q;
  assign bus_wdata     = bwdata_q;
  assign bus_wr        = wrp_q & ~addr_zero;
  assign bus_rd        = rdp_q & ~addr_zero;
  assign mode_we       = wrp_q & addr_zero;
  assign out_bit       = out_q;
  assign rd_active     = (state_q == FR_RDATA);
  assign act_four_wire = act_q.four_wire;
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_port_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic              csn_s, din_s, sclk_rise, sclk_fall;
  logic              mode_we, out_bit, rd_active, act_four_wire;
  port_mode_t        mode_cfg;
  logic [BYTE_W-1:0] mode_byte;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (spi_sclk),
    .csn_in    (spi_csn),
    .din_in    (spi_sdio_i),
    .csn_s     (csn_s),
    .din_s     (din_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  spi_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_we),
    .wr_bits (reg_wdata[1:0]),
    .mode    (mode_cfg),
    .rd_byte (mode_byte)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk_rise     (sclk_rise),
    .sclk_fall     (sclk_fall),
    .csn_s         (csn_s),
    .din_s         (din_s),
    .mode_cfg      (mode_cfg),
    .mode_byte     (mode_byte),
    .bus_rdata     (reg_rdata),
    .bus_addr      (reg_addr),
    .bus_wdata     (reg_wdata),
    .bus_wr        (reg_wr),
    .bus_rd        (reg_rd),
    .mode_we       (mode_we),
    .out_bit       (out_bit),
    .rd_active     (rd_active),
    .act_four_wire (act_four_wire)
  );

  assign spi_sdio_o  = out_bit;
  assign spi_sdo_o   = out_bit;
  assign spi_sdio_oe = rd_active & ~act_four_wire;
  assign spi_sdo_oe  = rd_active & act_four_wire;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_csn,
  input logic spi_sdio_oe,
  input logic spi_sdo_oe,
  input logic reg_wr,
  input logic reg_rd
);
  // R1: quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!reg_wr && !reg_rd && !spi_sdio_oe && !spi_sdo_oe));

  // R8 and R9: never both pins enabled
  a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_sdio_oe && spi_sdo_oe));

  // R5: one strobe type at a time, each a single-cycle pulse
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r5_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R11: select held high through the synchronizer leaves the port silent
  a_r11_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |-> (!spi_sdio_oe && !spi_sdo_oe && !reg_wr && !reg_rd));
endmodule

bind spi_slave_port spi_slave_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_csn     (spi_csn),
  .spi_sdio_oe (spi_sdio_oe),
  .spi_sdo_oe  (spi_sdo_oe),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd)
);

// File: tb/tb_spi_slave_port.sv
`timescale 1ns/1ps
module tb_spi_slave_port;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, spi_sclk, spi_csn, tb_dq;
  logic        spi_sdio_i, spi_sdio_o, spi_sdio_oe, spi_sdo_o, spi_sdo_oe;
  logic [12:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          finished = 0;
  logic [20:0] wq[$];
  string       wtag[$];
  logic [7:0]  rq[$];

  always #2.5 clk = ~clk;

  assign spi_sdio_i = spi_sdio_oe ? spi_sdio_o : tb_dq;
  assign reg_rdata  = reg_addr[7:0] ^ 8'hA5;

  spi_slave_port dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
    .spi_sdo_o(spi_sdo_o), .spi_sdo_oe(spi_sdo_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every write strobe pops one expected item
  always @(negedge clk) begin : mon
    logic [20:0] e;
    string t;
    if (rst_n && reg_wr) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R5/R11 unexpected write", {11'd0, reg_addr, reg_wdata}, 32'd0);
      end else begin
        e = wq.pop_front();
        t = wtag.pop_front();
        chk({reg_addr, reg_wdata} == e, t, {11'd0, reg_addr, reg_wdata}, {11'd0, e});
      end
    end
  end

  // one serial bit; obs = {sdio_oe, sdo_oe, sdio_o, sdo_o} taken just before the rise
  task automatic tick_bit(input logic b, output logic [3:0] obs);
    tb_dq = b;
    repeat (HALF) @(negedge clk);
    obs = {spi_sdio_oe, spi_sdo_oe, spi_sdio_o, spi_sdo_o};
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n, input logic lsb);
    logic [3:0] obs;
    for (int i = 0; i < n; i++) tick_bit(lsb ? w[i] : w[n-1-i], obs);
  endtask

  task automatic frame_open();
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic wr_frame(input logic lsb, input logic [1:0] cnt, input logic [12:0] a0,
                          input int n, input logic [31:0] bytes, input string tag);
    int lim;
    lim = (cnt == 2'd3) ? n : ((int'(cnt) + 1 < n) ? int'(cnt) + 1 : n);
    for (int i = 0; i < lim; i++) begin
      logic [12:0] a;
      a = lsb ? a0 + 13'(i) : a0 - 13'(i);
      if (a != 13'd0) begin
        wq.push_back({a, bytes[8*i +: 8]});
        wtag.push_back(tag);
      end
    end
    frame_open();
    send_bits({1'b0, cnt, a0}, 16, lsb);
    for (int i = 0; i < n; i++) send_bits({8'd0, bytes[8*i +: 8]}, 8, lsb);
    frame_close();
  endtask

  task automatic rd_frame(input logic lsb, input logic fourw, input logic [1:0] cnt,
                          input logic [12:0] a0, input int n, input logic [31:0] exp,
                          input bit extra, input string tag);
    logic [3:0] obs;
    for (int i = 0; i < n; i++) rq.push_back(exp[8*i +: 8]);
    frame_open();
    send_bits({1'b1, cnt, a0}, 16, lsb);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v, e;
      bit oe_ok;
      logic p;
      v = 8'd0;
      oe_ok = 1'b1;
      for (int k = 0; k < 8; k++) begin
        tick_bit(1'b0, obs);
        p = fourw ? obs[0] : obs[1];
        if (obs[3:2] != (fourw ? 2'b01 : 2'b10)) oe_ok = 1'b0;
        if (lsb) v[k] = p;
        else     v[7-k] = p;
      end
      e = rq.pop_front();
      chk(v == e, tag, {24'd0, v}, {24'd0, e});
      chk(oe_ok, fourw ? "R9 enable on dedicated output" : "R8 enable on shared pin",
          {31'd0, oe_ok}, 32'd1);
    end
    if (extra) begin
      tick_bit(1'b0, obs);
      chk(obs[3:2] == 2'b00, "R12 enable drops after last byte", {28'd0, obs}, 32'd0);
    end
    frame_close();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] obs;
    rst_n = 1'b1; spi_sclk = 1'b0; spi_csn = 1'b1; tb_dq = 1'b0;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({spi_sdio_oe, spi_sdo_oe, reg_wr, reg_rd} == 4'b0, "R1 reset quiet",
        {28'd0, spi_sdio_oe, spi_sdo_oe, reg_wr, reg_rd}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({spi_sdio_oe, spi_sdo_oe} == 2'b0, "R1 idle enables low",
        {30'd0, spi_sdio_oe, spi_sdo_oe}, 32'd0);

    // R6 reset mode byte, R8 3-wire, R10 first bit timing, R12
    rd_frame(1'b0, 1'b0, 2'd0, 13'h0000, 1, 32'h18, 1'b1, "R6 mode byte reset value");
    // R3 decrementing burst; R2 fourth byte beyond count ignored
    wr_frame(1'b0, 2'd2, 13'h0100, 4, 32'h77813CC3, "R3/R2 msb write burst");
    // R3 read burst, R12 after count
    rd_frame(1'b0, 1'b0, 2'd1, 13'h0050, 2, 32'h0000EAF5, 1'b1, "R3 msb read burst");
    // R7: mode byte set to lsb mid-frame, third byte still msb; R3 wrap down
    wr_frame(1'b0, 2'd3, 13'h0001, 3, 32'h00225A11, "R7/R3 stream through address 0");
    // R4 lsb write, increment
    wr_frame(1'b1, 2'd1, 13'h0200, 2, 32'h00008001, "R4 lsb write burst");
    // R4 wrap up into mode byte, R6 readback 0x5A
    rd_frame(1'b1, 1'b0, 2'd3, 13'h1FFE, 3, 32'h005A5A5B, 1'b0, "R4/R6 lsb read wrap");

    // R11 aborts: inside instruction, inside write byte, inside read byte
    frame_open(); send_bits(16'h0123, 10, 1'b1); frame_close();
    frame_open(); send_bits({1'b0, 2'd0, 13'h0300}, 16, 1'b1);
    send_bits(16'h001F, 5, 1'b1); frame_close();
    frame_open(); send_bits({1'b1, 2'd3, 13'h0040}, 16, 1'b1);
    for (int i = 0; i < 3; i++) tick_bit(1'b0, obs);
    frame_close();
    chk({spi_sdio_oe, spi_sdo_oe} == 2'b0, "R11 enables low after abort",
        {30'd0, spi_sdio_oe, spi_sdo_oe}, 32'd0);
    wr_frame(1'b1, 2'd0, 13'h0300, 1, 32'h0000005C, "R11 clean frame after aborts");

    // R7: switch to msb 4-wire (0x99), second byte still lsb-coded
    wr_frame(1'b1, 2'd3, 13'h0000, 2, 32'h00000F99, "R7 lsb byte after mode write");
    // R9 4-wire reads, R6 readback
    rd_frame(1'b0, 1'b1, 2'd0, 13'h0000, 1, 32'h99, 1'b1, "R9/R6 mode byte on dedicated output");
    rd_frame(1'b0, 1'b1, 2'd0, 13'h00A3, 1, 32'h06, 1'b1, "R9 register read on dedicated output");

    repeat (20) @(negedge clk);
    chk(wq.size() == 0, "R5 all expected writes seen", wq.size(), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule